// File: doc/BRIEF.md
# PCI Function Configuration Header Register File

This block holds the 256-byte configuration header of a single PCI function. Byte, word and dword accesses can be made at any byte address in the space. Writes are applied one byte at a time. A lock map that depends on the header type decides which bytes can be written, and reserved command and status bits always read back as zero. A full, aligned dword write to an implemented base address register (BAR) is handled as a sizing access instead. The written value is trimmed to the region size and the type bit is put back in, so software that writes all ones reads back the size mask.

The register file also watches the command register and every BAR, including the expansion ROM BAR. From them it produces a registered valid flag and a decoded base address per region. The rest of the chip uses these to steer I/O and memory decode. Region sizes and the I/O versus memory kind are build-time parameters, and sizes must be powers of two or zero (zero means not implemented).

Top module: `cfg_space_regs`

## Requirements
- R1: After reset, bytes 0x00–0x03 hold ID_WORD little-endian, bytes 0x0A–0x0B hold CLASS_WORD little-endian, and byte 0x0E holds HDR_TYPE. An implemented I/O BAR holds 0x00000001 and every other byte is zero. All bar_valid bits and all bar_base fields are zero.
- R2: Multi-byte values are little-endian. acc_len 0 selects a byte, 1 a word, and 2 or 3 a dword. Unused upper bits of rd_data are zero. rd_data always shows the current contents at acc_addr.
- R3: A dword read needs acc_addr ≤ 0xFC and otherwise falls back to a word read. A word read needs acc_addr ≤ 0xFE and otherwise falls back to a byte read.
- R4: A write (acc_valid and acc_write high at a clock edge) that is not a BAR sizing access stores byte i of acc_wdata, bits 8i+7..8i, at acc_addr+i for each byte of the access length. It stops at 0xFF and never wraps to 0x00.
- R5: With HDR_TYPE 0x00 or 0x80, byte writes have no effect on 0x00–0x03, 0x08–0x0B, 0x0E, 0x10–0x27, 0x2C–0x2F, 0x30–0x33 and 0x3D.
- R6: With any other HDR_TYPE, byte writes have no effect on 0x00–0x03, 0x08–0x0B, 0x0E, 0x2C–0x2F, 0x38–0x3B and 0x3D.
- R7: Byte writes store 0x05 ANDed with 0x07, 0x06 ANDed with 0xF8, and 0x07 ANDed with 0xF9.
- R8: A dword write at an aligned BAR offset 0x10+4n (n = 0..5) of a BAR with nonzero size S stores (data AND NOT(S−1)) OR t, where t is 1 for an I/O BAR and 0 for a memory BAR. An unaligned dword write, or a write to a BAR of size 0, follows R4–R7.
- R9: A dword write at 0x30 with ROM size S nonzero stores data AND (NOT(S−1) OR 1).
- R10: An I/O BAR decodes valid only when command bit 0 (byte 0x04) is set, the masked base is nonzero, and base+S−1 neither wraps nor reaches 0x10000.
- R11: A memory BAR or the ROM BAR decodes valid only when command bit 1 is set, the masked base is nonzero, and base+S−1 neither wraps nor equals 0xFFFFFFFF. The ROM additionally needs bit 0 of its register set.
- R12: bar_valid[s] and bar_base (slot s at bits 32s+31..32s, ROM in slot 6) change one clock after the write that alters the inputs of a region. bar_base is the masked base when the region is valid and zero otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Access strobe |
| acc_write | input | 1 | Write when high with acc_valid |
| acc_addr | input | 8 | Byte address of the access |
| acc_len | input | 2 | 0 byte, 1 word, 2 or 3 dword |
| acc_wdata | input | 32 | Write data, little-endian |
| rd_data | output | 32 | Read data for acc_addr and acc_len |
| bar_valid | output | 7 | Region decode valid, slot 6 is the ROM |
| bar_base | output | 224 | Decoded base per slot, 32 bits each |

## Verification
A corrupted byte in the array appears on rd_data as soon as that address is read, because the read path has no register. An exhaustive sweep that writes every byte and then reads every byte under both header-type families therefore exposes any lock-map, mask or store error directly. A wrong decode term appears on bar_valid or bar_base exactly one cycle after the write that set up the region. The checks therefore sample both right after the write, when the old value must still be shown, and one cycle later at each boundary of the I/O window, wrap limit and enable bit.

// File: rtl/cfgs_pkg.sv
// Shared constants and byte-policy helpers for the configuration header.
// Assumes a 256-byte space with six BARs plus one expansion ROM slot.
package cfgs_pkg;
    localparam int CFG_BYTES = 256;
    localparam int NUM_BARS  = 6;
    localparam int NUM_SLOTS = NUM_BARS + 1;
    localparam int ROM_SLOT  = NUM_BARS;
    localparam int SLOT_W    = $clog2(NUM_SLOTS);
    localparam int ADDR_W    = $clog2(CFG_BYTES);

    localparam logic [ADDR_W-1:0] CMD_OFS   = 8'h04;
    localparam logic [ADDR_W-1:0] HDR_OFS   = 8'h0E;
    localparam logic [ADDR_W-1:0] BAR_FIRST = 8'h10;
    localparam logic [ADDR_W-1:0] ROM_OFS   = 8'h30;

    typedef enum logic [1:0] {
        LEN_BYTE  = 2'd0,
        LEN_WORD  = 2'd1,
        LEN_DWORD = 2'd2,
        LEN_DWALT = 2'd3
    } acc_len_e;

    // Byte offset of the register for a region slot.
    function automatic logic [ADDR_W-1:0] slot_offset(input int s);
        if (s == ROM_SLOT) return ROM_OFS;
        return ADDR_W'(BAR_FIRST + ADDR_W'(4 * s));
    endfunction

    // True when a byte write to address a is ignored for header type hdr.
    function automatic logic byte_locked(input logic [7:0] hdr, input logic [ADDR_W-1:0] a);
        logic common;
        common = (a <= 8'h03) || (a >= 8'h08 && a <= 8'h0B) || (a == 8'h0E) ||
                 (a >= 8'h2C && a <= 8'h2F) || (a == 8'h3D);
        if (hdr == 8'h00 || hdr == 8'h80)
            return common || (a >= 8'h10 && a <= 8'h27) || (a >= 8'h30 && a <= 8'h33);
        return common || (a >= 8'h38 && a <= 8'h3B);
    endfunction

    // Writable-bit mask that clears reserved command/status bits.
    function automatic logic [7:0] byte_wmask(input logic [ADDR_W-1:0] a);
        case (a)
            8'h05:   return 8'h07;
            8'h06:   return 8'hF8;
            8'h07:   return 8'hF9;
            default: return 8'hFF;
        endcase
    endfunction
endpackage

// File: rtl/cfgs_bar_path.sv
// Detects a BAR sizing write and forms the word to store.
// Assumes region sizes are zero or powers of two; only aligned dword
// writes to an implemented slot take this path, all others go byte-wise.
module cfgs_bar_path import cfgs_pkg::*; #(
    parameter logic [NUM_SLOTS-1:0][31:0] SLOT_SIZE = '0,
    parameter logic [NUM_BARS-1:0]        BAR_IS_IO = '0
) (
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [1:0]        acc_len,
    input  logic [31:0]       acc_wdata,
    output logic              hit,
    output logic [ADDR_W-1:0] bar_ofs,
    output logic [31:0]       store_word
);
    localparam logic [NUM_SLOTS-1:0] IO_MAP = {1'b0, BAR_IS_IO};
    localparam logic [ADDR_W-1:0]    BAR_END = ADDR_W'(BAR_FIRST + ADDR_W'(4 * NUM_BARS));

    logic [SLOT_W-1:0] slot;
    logic              in_win;
    logic [31:0]       sz;
    logic [31:0]       keep;

    // Map the access address to a region slot.
    always_comb begin
        slot   = '0;
        in_win = 1'b0;
        if (acc_addr >= BAR_FIRST && acc_addr < BAR_END) begin
            in_win = 1'b1;
            slot   = SLOT_W'((acc_addr - BAR_FIRST) >> 2);
        end else if (acc_addr[ADDR_W-1:2] == ROM_OFS[ADDR_W-1:2]) begin
            in_win = 1'b1;
            slot   = SLOT_W'(ROM_SLOT);
        end
    end

    // Trim the written word to the region size and restore fixed bits.
    always_comb begin
        sz   = SLOT_SIZE[slot];
        keep = ~(sz - 32'd1);
        hit  = acc_valid && acc_write && acc_len[1] && (acc_addr[1:0] == 2'b00) &&
               in_win && (sz != 32'd0);
        if (slot == SLOT_W'(ROM_SLOT)) begin
            store_word = acc_wdata & (keep | 32'd1);
            bar_ofs    = ROM_OFS;
        end else begin
            store_word = (acc_wdata & keep) | {31'b0, IO_MAP[slot]};
            bar_ofs    = ADDR_W'(BAR_FIRST + {slot, 2'b00});
        end
    end
endmodule

// File: rtl/cfgs_bar_decode.sv
// Registered decode of one region: valid flag and masked base address.
// Assumes SIZE is zero (unimplemented, never valid) or a power of two.
module cfgs_bar_decode #(
    parameter logic [31:0] SIZE   = 32'd0,
    parameter logic        IS_IO  = 1'b0,
    parameter logic        IS_ROM = 1'b0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] bar_word,
    input  logic        io_en,
    input  logic        mem_en,
    output logic        valid_q,
    output logic [31:0] base_q
);
    localparam logic        IMPL = (SIZE != 32'd0);
    localparam logic [31:0] KEEP = ~(SIZE - 32'd1);

    logic [31:0] masked;
    logic [32:0] last;
    logic        ok;

    // Evaluate the mapping rules for the current register contents.
    always_comb begin
        masked = bar_word & KEEP;
        last   = {1'b0, masked} + {1'b0, SIZE} - 33'd1;
        if (IS_IO)
            ok = io_en && (masked != 32'd0) && !last[32] && (last[31:16] == 16'd0);
        else
            ok = mem_en && (masked != 32'd0) && !last[32] && (last[31:0] != 32'hFFFF_FFFF) &&
                 (!IS_ROM || bar_word[0]);
        ok = ok && IMPL;
    end

    // Hold the decode result for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            base_q  <= '0;
        end else begin
            valid_q <= ok;
            base_q  <= ok ? masked : 32'd0;
        end
    end

    assert_base_nonzero_R12: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |-> (base_q != 32'd0));
    assert_base_aligned_R8: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |-> ((base_q & (SIZE - 32'd1)) == 32'd0));

    if (IS_IO) begin : g_io_chk
        assert_io_window_R10: assert property (@(posedge clk) disable iff (!rst_n)
            valid_q |-> (({1'b0, base_q} + {1'b0, SIZE} - 33'd1) < 33'h1_0000));
        assert_io_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
            valid_q |-> $past(io_en));
    end else begin : g_mem_chk
        assert_mem_enable_R11: assert property (@(posedge clk) disable iff (!rst_n)
            valid_q |-> $past(mem_en));
        assert_mem_nowrap_R11: assert property (@(posedge clk) disable iff (!rst_n)
            valid_q |-> (({1'b0, base_q} + {1'b0, SIZE} - 33'd1) < 33'h0_FFFF_FFFF));
    end
    if (IS_ROM) begin : g_rom_chk
        assert_rom_enable_R11: assert property (@(posedge clk) disable iff (!rst_n)
            valid_q |-> $past(bar_word[0]));
    end
endmodule

// File: rtl/cfgs_read_port.sv
// Combinational read of 1, 2 or 4 bytes, little-endian, narrowing the
// width when the access would run past the last byte.
module cfgs_read_port import cfgs_pkg::*; (
    input  logic [CFG_BYTES-1:0][7:0] cfg,
    input  logic [ADDR_W-1:0]         acc_addr,
    input  logic [1:0]                acc_len,
    output logic [31:0]               rd_data
);
    logic [7:0] b0, b1, b2, b3;
    logic       fit_dw, fit_w;

    // Pick bytes and choose the widest width that stays in range.
    always_comb begin
        b0     = cfg[acc_addr];
        b1     = cfg[ADDR_W'(acc_addr + 8'd1)];
        b2     = cfg[ADDR_W'(acc_addr + 8'd2)];
        b3     = cfg[ADDR_W'(acc_addr + 8'd3)];
        fit_dw = (acc_addr <= 8'hFC);
        fit_w  = (acc_addr <= 8'hFE);
        case (acc_len)
            LEN_DWORD, LEN_DWALT:
                rd_data = fit_dw ? {b3, b2, b1, b0} :
                          fit_w  ? {16'd0, b1, b0} : {24'd0, b0};
            LEN_WORD:
                rd_data = fit_w ? {16'd0, b1, b0} : {24'd0, b0};
            default:
                rd_data = {24'd0, b0};
        endcase
    end
endmodule

// File: rtl/cfg_space_regs.sv
// Configuration header of one PCI function: byte array, per-byte write
// policy, BAR sizing writes and registered region decode.
// Assumes sizes in SLOT_SIZE are zero or powers of two, slot 6 is the ROM.
module cfg_space_regs import cfgs_pkg::*; #(
    parameter logic [31:0] ID_WORD    = 32'h1234_ABCD,
    parameter logic [15:0] CLASS_WORD = 16'h0200,
    parameter logic [7:0]  HDR_TYPE   = 8'h00,
    parameter logic [NUM_SLOTS-1:0][31:0] SLOT_SIZE =
        {32'd2048, 32'd0, 32'd0, 32'd0, 32'd256, 32'd4096, 32'd16},
    parameter logic [NUM_BARS-1:0] BAR_IS_IO = 6'b000001
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    acc_valid,
    input  logic                    acc_write,
    input  logic [ADDR_W-1:0]       acc_addr,
    input  logic [1:0]              acc_len,
    input  logic [31:0]             acc_wdata,
    output logic [31:0]             rd_data,
    output logic [NUM_SLOTS-1:0]    bar_valid,
    output logic [NUM_SLOTS*32-1:0] bar_base
);
    localparam logic [NUM_SLOTS-1:0] IO_MAP = {1'b0, BAR_IS_IO};

    logic [CFG_BYTES-1:0][7:0] cfg_q, cfg_d;
    logic [2:0]                acc_nbytes;
    logic [ADDR_W:0]           rel;
    logic                      bar_hit;
    logic [ADDR_W-1:0]         bar_ofs;
    logic [31:0]               bar_store;

    // Contents of the header after reset.
    function automatic logic [CFG_BYTES-1:0][7:0] reset_image();
        logic [CFG_BYTES-1:0][7:0] img;
        img       = '0;
        img[0]    = ID_WORD[7:0];
        img[1]    = ID_WORD[15:8];
        img[2]    = ID_WORD[23:16];
        img[3]    = ID_WORD[31:24];
        img[10]   = CLASS_WORD[7:0];
        img[11]   = CLASS_WORD[15:8];
        img[HDR_OFS] = HDR_TYPE;
        for (int s = 0; s < NUM_BARS; s++)
            if (SLOT_SIZE[s] != 32'd0 && BAR_IS_IO[s]) img[slot_offset(s)] = 8'h01;
        return img;
    endfunction

    // Number of bytes covered by the access.
    always_comb begin
        case (acc_len)
            LEN_BYTE: acc_nbytes = 3'd1;
            LEN_WORD: acc_nbytes = 3'd2;
            default:  acc_nbytes = 3'd4;
        endcase
    end

    cfgs_bar_path #(
        .SLOT_SIZE (SLOT_SIZE),
        .BAR_IS_IO (BAR_IS_IO)
    ) u_bar_path (
        .acc_valid  (acc_valid),
        .acc_write  (acc_write),
        .acc_addr   (acc_addr),
        .acc_len    (acc_len),
        .acc_wdata  (acc_wdata),
        .hit        (bar_hit),
        .bar_ofs    (bar_ofs),
        .store_word (bar_store)
    );

    // Next-state of every byte: sizing store or policed byte write.
    always_comb begin
        cfg_d = cfg_q;
        rel   = '0;
        for (int b = 0; b < CFG_BYTES; b++) begin
            rel = (ADDR_W+1)'(b) - {1'b0, acc_addr};
            if (bar_hit) begin
                if ((ADDR_W'(b) & 8'hFC) == bar_ofs)
                    cfg_d[b] = bar_store[8*(b%4) +: 8];
            end else if (acc_valid && acc_write && (rel < {6'd0, acc_nbytes}) &&
                         !byte_locked(HDR_TYPE, ADDR_W'(b))) begin
                cfg_d[b] = 8'(acc_wdata >> {rel[1:0], 3'b000}) & byte_wmask(ADDR_W'(b));
            end
        end
    end

    // Byte array storage.
    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= reset_image();
        else        cfg_q <= cfg_d;
    end

    cfgs_read_port u_read_port (
        .cfg      (cfg_q),
        .acc_addr (acc_addr),
        .acc_len  (acc_len),
        .rd_data  (rd_data)
    );

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        localparam int OFS = int'(slot_offset(s));
        cfgs_bar_decode #(
            .SIZE   (SLOT_SIZE[s]),
            .IS_IO  (IO_MAP[s]),
            .IS_ROM (s == ROM_SLOT)
        ) u_decode (
            .clk      (clk),
            .rst_n    (rst_n),
            .bar_word ({cfg_q[OFS+3], cfg_q[OFS+2], cfg_q[OFS+1], cfg_q[OFS]}),
            .io_en    (cfg_q[CMD_OFS][0]),
            .mem_en   (cfg_q[CMD_OFS][1]),
            .valid_q  (bar_valid[s]),
            .base_q   (bar_base[32*s +: 32])
        );
    end

    assert_rsv_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q[5][7:3] == 5'd0) && (cfg_q[6][2:0] == 3'd0) && (cfg_q[7][2:1] == 2'd0));
    assert_hdr_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q[HDR_OFS] == HDR_TYPE);
    assert_id_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        {cfg_q[3], cfg_q[2], cfg_q[1], cfg_q[0]} == ID_WORD);
    assert_rd_narrow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_addr == 8'hFF) |-> (rd_data[31:8] == 24'd0));
endmodule

// File: tb/tb_cfg_space_regs.sv
`timescale 1ns/1ps
module tb_cfg_space_regs;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic        a_valid = 0, a_write = 0, b_valid = 0, b_write = 0;
    logic [7:0]  a_addr = 0, b_addr = 0;
    logic [1:0]  a_len = 0, b_len = 0;
    logic [31:0] a_wdata = 0, b_wdata = 0, a_rd, b_rd;
    logic [6:0]  a_bv, b_bv;
    logic [223:0] a_bb, b_bb;

    int nchk = 0, nerr = 0;
    bit done = 0;
    logic [7:0] ma [256];
    logic [7:0] mb [256];

    cfg_space_regs dut (
        .clk(clk), .rst_n(rst_n), .acc_valid(a_valid), .acc_write(a_write),
        .acc_addr(a_addr), .acc_len(a_len), .acc_wdata(a_wdata),
        .rd_data(a_rd), .bar_valid(a_bv), .bar_base(a_bb));

    cfg_space_regs #(.HDR_TYPE(8'h01)) dut_b (
        .clk(clk), .rst_n(rst_n), .acc_valid(b_valid), .acc_write(b_write),
        .acc_addr(b_addr), .acc_len(b_len), .acc_wdata(b_wdata),
        .rd_data(b_rd), .bar_valid(b_bv), .bar_base(b_bb));

    function automatic bit locked(input bit hdr_one, input int a);
        bit c = (a <= 3) || (a >= 8 && a <= 11) || a == 14 || (a >= 'h2C && a <= 'h2F) || a == 'h3D;
        if (!hdr_one) return c || (a >= 'h10 && a <= 'h27) || (a >= 'h30 && a <= 'h33);
        return c || (a >= 'h38 && a <= 'h3B);
    endfunction

    function automatic logic [7:0] wmask(input int a);
        if (a == 5) return 8'h07;
        if (a == 6) return 8'hF8;
        if (a == 7) return 8'hF9;
        return 8'hFF;
    endfunction

    function automatic logic [7:0] rst_byte(input bit hdr_one, input int a);
        case (a)
            0: return 8'hCD; 1: return 8'hAB; 2: return 8'h34; 3: return 8'h12;
            10: return 8'h00; 11: return 8'h02;
            14: return hdr_one ? 8'h01 : 8'h00;
            'h10: return 8'h01;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 37 + 11) & 255);
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
        nchk++;
        if (got !== exp) begin
            nerr++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic drive(input bit sel, input logic v, input logic [7:0] ad, input logic [1:0] ln, input logic [31:0] wd);
        if (sel) begin b_valid = v; b_write = v; b_addr = ad; b_len = ln; b_wdata = wd; end
        else     begin a_valid = v; a_write = v; a_addr = ad; a_len = ln; a_wdata = wd; end
    endtask

    // Write; returns at the falling edge after the capturing edge.
    task automatic wr(input bit sel, input logic [7:0] ad, input logic [1:0] ln, input logic [31:0] wd);
        @(negedge clk); drive(sel, 1'b1, ad, ln, wd);
        @(negedge clk); drive(sel, 1'b0, ad, ln, 32'd0);
    endtask

    // Bench model of a non-sizing write.
    task automatic mwr(input bit sel, input int ad, input int nb, input logic [31:0] wd);
        for (int i = 0; i < nb; i++) begin
            int a = ad + i;
            logic [7:0] v = 8'(wd >> (8 * i));
            if (a > 255) break;
            if (!locked(sel, a)) begin
                if (sel) mb[a] = v & wmask(a); else ma[a] = v & wmask(a);
            end
        end
    endtask

    task automatic rd(input bit sel, input logic [7:0] ad, input logic [1:0] ln, output logic [31:0] v);
        drive(sel, 1'b0, ad, ln, 32'd0);
        #1;
        v = sel ? b_rd : a_rd;
    endtask

    task automatic settle();
        @(negedge clk);
    endtask

    task automatic chk_dec(input string req, input int s, input logic v, input logic [31:0] base);
        chk(req, $sformatf("slot %0d valid", s), {31'd0, a_bv[s]}, {31'd0, v});
        chk(req, $sformatf("slot %0d base", s), a_bb[32*s +: 32], base);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        for (int a = 0; a < 256; a++) begin ma[a] = rst_byte(0, a); mb[a] = rst_byte(1, a); end
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(0, 8'h00, 2'd2, v); chk("R1", "id dword", v, 32'h1234ABCD);
        rd(0, 8'h0A, 2'd1, v); chk("R1", "class word", v, 32'h0200);
        rd(0, 8'h0E, 2'd0, v); chk("R1", "header A", v, 32'h00);
        rd(1, 8'h0E, 2'd0, v); chk("R1", "header B", v, 32'h01);
        rd(0, 8'h10, 2'd2, v); chk("R1", "io bar reset", v, 32'h1);
        rd(0, 8'h30, 2'd2, v); chk("R1", "rom reset", v, 32'h0);
        chk("R1", "valid A", {25'd0, a_bv}, 32'd0);
        chk("R1", "valid B", {25'd0, b_bv}, 32'd0);
        chk("R1", "bases A", {31'd0, a_bb != '0}, 32'd0);
        rd(0, 8'h00, 2'd3, v); chk("R2", "len 3 is dword", v, 32'h1234ABCD);

        // R4 R5 R6 R7 exhaustive byte sweep on both header families
        for (int a = 0; a < 256; a++) begin
            wr(0, 8'(a), 2'd0, {24'd0, pat(a)});       mwr(0, a, 1, {24'd0, pat(a)});
            wr(1, 8'(a), 2'd0, {24'd0, ~pat(a)});      mwr(1, a, 1, {24'd0, ~pat(a)});
        end
        for (int a = 0; a < 256; a++) begin
            string r;
            rd(0, 8'(a), 2'd0, v);
            r = (a >= 5 && a <= 7) ? "R7" : "R5";
            chk(r, $sformatf("hdr0 byte %02h", a), v, {24'd0, ma[a]});
            rd(1, 8'(a), 2'd0, v);
            r = (a >= 5 && a <= 7) ? "R7" : "R6";
            chk(r, $sformatf("hdr1 byte %02h", a), v, {24'd0, mb[a]});
        end

        // R4 R5 multi-byte writes across a locked byte
        wr(0, 8'h3C, 2'd2, 32'h44332211); mwr(0, 'h3C, 4, 32'h44332211);
        rd(0, 8'h3C, 2'd2, v); chk("R5", "dword over 3D", v, {ma['h3F], ma['h3E], ma['h3D], ma['h3C]});
        wr(0, 8'h40, 2'd2, 32'hDEADBEEF); mwr(0, 'h40, 4, 32'hDEADBEEF);
        rd(0, 8'h41, 2'd1, v); chk("R2", "word inside dword", v, 32'h0000ADBE);
        rd(0, 8'h40, 2'd2, v); chk("R4", "dword store", v, 32'hDEADBEEF);
        wr(1, 8'hFE, 2'd2, 32'hAABBCCDD); mwr(1, 'hFE, 4, 32'hAABBCCDD);
        rd(1, 8'hFC, 2'd2, v); chk("R4", "stop at FF", v, {8'hCC, 8'hDD, mb['hFD], mb['hFC]});
        rd(1, 8'h00, 2'd2, v); chk("R4", "no wrap to 00", v, 32'h1234ABCD);

        // R3 width fallback
        rd(0, 8'hFC, 2'd2, v); chk("R3", "dword at FC", v, {ma['hFF], ma['hFE], ma['hFD], ma['hFC]});
        rd(0, 8'hFD, 2'd2, v); chk("R3", "dword at FD", v, {16'd0, ma['hFE], ma['hFD]});
        rd(0, 8'hFF, 2'd2, v); chk("R3", "dword at FF", v, {24'd0, ma['hFF]});
        rd(0, 8'hFE, 2'd1, v); chk("R3", "word at FE", v, {16'd0, ma['hFF], ma['hFE]});
        rd(0, 8'hFF, 2'd1, v); chk("R3", "word at FF", v, {24'd0, ma['hFF]});

        // R8 R9 sizing writes
        wr(0, 8'h10, 2'd2, 32'hFFFFFFFF); rd(0, 8'h10, 2'd2, v); chk("R8", "io size", v, 32'hFFFFFFF1);
        wr(0, 8'h14, 2'd2, 32'hFFFFFFFF); rd(0, 8'h14, 2'd2, v); chk("R8", "mem 4k size", v, 32'hFFFFF000);
        wr(0, 8'h18, 2'd2, 32'hFFFFFFFF); rd(0, 8'h18, 2'd2, v); chk("R8", "mem 256 size", v, 32'hFFFFFF00);
        wr(0, 8'h1C, 2'd2, 32'hFFFFFFFF); rd(0, 8'h1C, 2'd2, v); chk("R8", "size zero bar", v, 32'h0);
        wr(0, 8'h30, 2'd2, 32'hFFFFFFFF); rd(0, 8'h30, 2'd2, v); chk("R9", "rom size", v, 32'hFFFFF801);
        wr(0, 8'h11, 2'd2, 32'h0);        rd(0, 8'h10, 2'd2, v); chk("R8", "unaligned bytewise", v, 32'hFFFFFFF1);

        // R10 R12 I/O decode and timing
        wr(0, 8'h04, 2'd0, 32'h0);
        wr(0, 8'h10, 2'd3, 32'h0000C000); settle();
        chk_dec("R10", 0, 1'b0, 32'h0);
        wr(0, 8'h04, 2'd0, 32'h1);
        chk_dec("R12", 0, 1'b0, 32'h0);
        settle();
        chk_dec("R12", 0, 1'b1, 32'h0000C000);
        wr(0, 8'h10, 2'd2, 32'h0000FFF0); settle(); chk_dec("R10", 0, 1'b1, 32'h0000FFF0);
        wr(0, 8'h10, 2'd2, 32'h00010000); settle(); chk_dec("R10", 0, 1'b0, 32'h0);
        wr(0, 8'h10, 2'd2, 32'h00000000); settle(); chk_dec("R10", 0, 1'b0, 32'h0);
        wr(0, 8'h10, 2'd2, 32'h0000C000);
        wr(0, 8'h04, 2'd0, 32'h2); settle();
        chk_dec("R10", 0, 1'b0, 32'h0);

        // R11 memory and ROM decode
        chk_dec("R11", 1, 1'b0, 32'h0);
        wr(0, 8'h14, 2'd2, 32'hFFFFE000); settle(); chk_dec("R11", 1, 1'b1, 32'hFFFFE000);
        wr(0, 8'h18, 2'd2, 32'h12345678);
        rd(0, 8'h18, 2'd2, v); chk("R8", "mem store", v, 32'h12345600);
        settle(); chk_dec("R11", 2, 1'b1, 32'h12345600);
        wr(0, 8'h30, 2'd2, 32'h00010000);
        rd(0, 8'h30, 2'd2, v); chk("R9", "rom store", v, 32'h00010000);
        settle(); chk_dec("R11", 6, 1'b0, 32'h0);
        wr(0, 8'h30, 2'd2, 32'h00010001); settle(); chk_dec("R11", 6, 1'b1, 32'h00010000);
        wr(0, 8'h04, 2'd0, 32'h1); settle();
        chk_dec("R11", 6, 1'b0, 32'h0);
        chk_dec("R11", 1, 1'b0, 32'h0);
        chk_dec("R10", 0, 1'b1, 32'h0000C000);
        chk_dec("R11", 3, 1'b0, 32'h0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule